// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. Software programs it through four byte-wide addresses. A control register carries enable, start/busy, a two-bit input channel, a reference choice and a result format bit. A clock register picks the conversion clock period (TAD). When a conversion is started, the block builds a trial code one bit per TAD, from the most significant bit down. It drives each trial code to an external DAC and reads back a one-bit comparator decision. It then packs the final code into a high and a low result byte.

The sample-and-hold, the DAC, the comparator and the input multiplexer are outside the block. The block only presents the channel and reference selections to them as outputs. The TAD comes either from a power-of-two division of the system clock or from the rising edges of a separate slow oscillator input. That oscillator is synchronized into the system clock domain before its edges are used.

Top module: `sar_seq`

## Requirements
- R1: After reset, all four readable addresses return 0, and dac_code, chan_sel, ref_sel and done_irq are 0.
- R2: Conversion is successive approximation. The first TAD is setup with dac_code = 0. In each of the next ten TADs one bit is set, MSB first, and is kept when cmp_in is 1 at the end of that TAD and cleared when it is 0. For an input value v, with the comparator reporting v >= dac_code, the result equals v.
- R3: A conversion lasts exactly 11 TADs. With a system-clock division of 2^k, done_irq goes high exactly 11*2^k clock cycles after the clock edge that accepted the start write.
- R4: Clock register (address 1) field bits 6:4 select the TAD. Code 000 is /2, 100 is /4, 001 is /8, 101 is /16, 010 is /32 and 110 is /64. Other bits of that register read 0.
- R5: Clock field codes 011 and 111 use the rising edges of osc_in, sampled through a two-flop synchronizer, as TAD boundaries. Conversion gives the same result in this mode.
- R6: With format bit 7 of the control register set, the high byte (address 2) is {6'b0, result[9:8]} and the low byte (address 3) is result[7:0].
- R7: With format bit 7 clear, the high byte is result[9:2] and the low byte is {result[1:0], 6'b0}.
- R8: The control register (address 0) has these fields: bit 0 enable, bit 1 start/busy, bits 3:2 channel, bit 6 reference, bit 7 format. Bits 5:4 read 0. When a conversion completes, the block clears bit 1, loads both result bytes, and pulses done_irq high for exactly one cycle.
- R9: While bit 1 is set, writes to the channel, the reference and the clock field are ignored. Writing 0 to bit 1 does not stop the conversion.
- R10: Writing the control register with bit 0 clear during a conversion aborts it at once. Bit 1 clears, the result bytes are unchanged, and done_irq does not pulse.
- R11: chan_sel follows control bits 3:2 and ref_sel follows control bit 6. Both change only when a write is accepted.
- R12: A write with bit 1 set but bit 0 clear starts nothing. Bit 1 stays 0 and no done_irq follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address for both read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Combinational read data at addr |
| osc_in | input | 1 | Dedicated slow oscillator, asynchronous |
| cmp_in | input | 1 | Comparator decision, 1 when input >= DAC level |
| dac_code | output | 10 | Trial code to the DAC |
| chan_sel | output | 2 | Selected input channel |
| ref_sel | output | 1 | 1 selects external reference, 0 the supply |
| done_irq | output | 1 | One-cycle conversion-complete pulse |

## Verification
The bench uses the default parameters: a 10-bit result, 8-bit registers and a 6-bit divider counter. This makes every one of the six divisions reachable, including the /64 setting, where a conversion takes 704 cycles. It also covers both packing formats across the 16-bit register pair, and the oscillator path with an input whose period is fourteen system clocks. Random input values, channels, references and formats are mixed with directed cases: extreme codes, a write during a busy conversion, an abort, and a start without enable.

// File: rtl/sar_seq.sv
module sar_seq #(
  parameter int RES_W  = 10,
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              osc_in,
  input  logic              cmp_in,
  output logic [RES_W-1:0]  dac_code,
  output logic [1:0]        chan_sel,
  output logic              ref_sel,
  output logic              done_irq
);
  localparam int CNT_W = $clog2(RES_W + 1);
  localparam int PAD   = 2 * DATA_W - RES_W;

  logic              en_q, go_q, ref_q, fmt_q, irq_q;
  logic [1:0]        chan_q;
  logic [2:0]        cks_q;
  logic [RES_W-1:0]  res_q, trial_q, trial_nx;
  logic [CNT_W-1:0]  tad_q;
  logic [DIV_W-1:0]  div_q, mask;
  logic [DIV_W:0]    one_sh;
  logic [2:0]        osc_s;
  logic [2:0]        shift;
  logic              osc_rise, tick, wr_ctl, wr_cks, start, abort;
  logic [2*DATA_W-1:0] packed_res;

  assign wr_ctl = wr_en && addr == 2'd0;
  assign wr_cks = wr_en && addr == 2'd1;
  assign start  = wr_ctl && !go_q && wr_data[0] && wr_data[1];
  assign abort  = wr_ctl && go_q && !wr_data[0];

  assign shift  = cks_q[2] ? {cks_q[1:0], 1'b0} + 3'd2 : {cks_q[1:0], 1'b0} + 3'd1;
  assign one_sh = (DIV_W+1)'(1) << shift;
  assign mask   = one_sh[DIV_W-1:0] - DIV_W'(1);
  assign osc_rise = osc_s[1] && !osc_s[2];
  assign tick   = go_q && ((cks_q[1:0] == 2'b11) ? osc_rise : ((div_q & mask) == mask));

  always_comb begin
    trial_nx = trial_q;
    for (int i = 0; i < RES_W; i++) begin
      if (i == RES_W - int'(tad_q) && !cmp_in) trial_nx[i] = 1'b0;
      if (i + 1 == RES_W - int'(tad_q)) trial_nx[i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) osc_s <= '0;
    else        osc_s <= {osc_s[1:0], osc_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; ref_q <= 1'b0; fmt_q <= 1'b0; chan_q <= '0; cks_q <= '0;
    end else begin
      if (wr_ctl) begin
        en_q  <= wr_data[0];
        fmt_q <= wr_data[7];
        if (!go_q) begin
          chan_q <= wr_data[3:2];
          ref_q  <= wr_data[6];
        end
      end
      if (wr_cks && !go_q) cks_q <= wr_data[6:4];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      go_q <= 1'b0; irq_q <= 1'b0; tad_q <= '0; div_q <= '0;
      trial_q <= '0; res_q <= '0;
    end else begin
      irq_q <= 1'b0;
      if (start) begin
        go_q <= 1'b1; tad_q <= '0; div_q <= '0; trial_q <= '0;
      end else if (abort) begin
        go_q <= 1'b0;
      end else if (go_q) begin
        div_q <= div_q + DIV_W'(1);
        if (tick) begin
          if (tad_q == '0) begin
            trial_q <= RES_W'(1) << (RES_W - 1);
            tad_q   <= CNT_W'(1);
          end else begin
            trial_q <= trial_nx;
            if (tad_q == CNT_W'(RES_W)) begin
              res_q <= trial_nx;
              go_q  <= 1'b0;
              irq_q <= 1'b1;
            end else begin
              tad_q <= tad_q + CNT_W'(1);
            end
          end
        end
      end
    end
  end

  assign packed_res = fmt_q ? {{PAD{1'b0}}, res_q} : {res_q, {PAD{1'b0}}};

  always_comb begin
    case (addr)
      2'd0:    rd_data = DATA_W'({fmt_q, ref_q, 2'b00, chan_q, go_q, en_q});
      2'd1:    rd_data = DATA_W'({1'b0, cks_q, 4'b0000});
      2'd2:    rd_data = packed_res[2*DATA_W-1:DATA_W];
      default: rd_data = packed_res[DATA_W-1:0];
    endcase
  end

  assign dac_code = trial_q;
  assign chan_sel = chan_q;
  assign ref_sel  = ref_q;
  assign done_irq = irq_q;
endmodule

// File: rtl/sar_seq_chk.sv
module sar_seq_chk #(
  parameter int RES_W = 10,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             go_q,
  input logic             done_irq,
  input logic [1:0]       chan_sel,
  input logic             ref_sel,
  input logic [RES_W-1:0] dac_code,
  input logic [CNT_W-1:0] tad_q
);
  // R8
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);
  // R8
  irq_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> (!go_q && $past(go_q)));
  // R9
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && $past(go_q)) |-> ($stable(chan_sel) && $stable(ref_sel)));
  // R2
  dac_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!go_q && !$past(go_q)) |-> $stable(dac_code));
  // R3
  tad_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tad_q <= CNT_W'(RES_W));
  // R2
  setup_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && tad_q == '0) |-> dac_code == '0);
endmodule

bind sar_seq sar_seq_chk #(.RES_W(RES_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .go_q(go_q), .done_irq(done_irq),
  .chan_sel(chan_sel), .ref_sel(ref_sel), .dac_code(dac_code), .tad_q(tad_q)
);

// File: tb/tb_sar_seq.sv
`timescale 1ns/1ps
module tb_sar_seq;
  logic       clk = 0, rst_n = 0, wr_en = 0, osc_in = 0;
  logic [1:0] addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [9:0] dac_code, vin = 0;
  logic [1:0] chan_sel;
  logic       ref_sel, done_irq, cmp_in;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;
  always #35 osc_in = ~osc_in;
  assign cmp_in = (vin >= dac_code);

  sar_seq dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .osc_in(osc_in), .cmp_in(cmp_in), .dac_code(dac_code),
    .chan_sel(chan_sel), .ref_sel(ref_sel), .done_irq(done_irq));

  function automatic int div_shift(input logic [2:0] s);
    return s[2] ? 2 * s[1:0] + 2 : 2 * s[1:0] + 1;
  endfunction
  function automatic logic [7:0] exp_hi(input logic [9:0] v, input logic f);
    return f ? {6'b0, v[9:8]} : v[9:2];
  endfunction
  function automatic logic [7:0] exp_lo(input logic [9:0] v, input logic f);
    return f ? v[7:0] : {v[1:0], 6'b0};
  endfunction

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rd_data;
  endtask

  task automatic wait_irq(input int limit, output int n);
    n = 0;
    while (n < limit) begin
      @(negedge clk); n++;
      if (done_irq) return;
    end
    n = -1;
  endtask

  task automatic convert(input logic [2:0] sel, input logic [9:0] v, input logic f,
                         input logic [1:0] ch, input logic rf, input bit timed);
    int n;
    logic [7:0] d;
    vin = v;
    wr(2'd1, {1'b0, sel, 4'b0});
    wr(2'd0, {f, rf, 2'b00, ch, 2'b11});
    check("R11 chan_sel", chan_sel, ch);
    check("R11 ref_sel", ref_sel, rf);
    wait_irq(3000, n);
    if (timed) check("R3 cycles to done", n, 11 * (1 << div_shift(sel)));
    else       check("R5 osc conversion completes", n > 0, 1);
    @(negedge clk);
    check("R8 irq one cycle", done_irq, 0);
    rd(2'd0, d);
    check("R8 busy cleared", d[1], 0);
    rd(2'd2, d);
    check(f ? "R6 high byte" : "R7 high byte", d, exp_hi(v, f));
    rd(2'd3, d);
    check(f ? "R6 low byte" : "R7 low byte", d, exp_lo(v, f));
    check("R2 final code", dac_code, v);
  endtask

  initial begin
    #1000000;
    bad++; total++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int n;
    logic [2:0] divs [6] = '{3'b000, 3'b100, 3'b001, 3'b101, 3'b010, 3'b110};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      check("R1 reset register", d, 0);
    end
    check("R1 reset outputs", {dac_code, chan_sel, ref_sel, done_irq}, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R4 every division, R6/R7 both formats, R2 extreme codes
    for (int i = 0; i < 6; i++) begin
      convert(divs[i], 10'd1023, 1'b1, 2'(i), i[0], 1);
      convert(divs[i], 10'd0, 1'b0, 2'(i + 1), i[1], 1);
    end
    convert(3'b000, 10'd512, 1'b1, 2'd3, 1'b1, 1);
    convert(3'b100, 10'd341, 1'b0, 2'd2, 1'b0, 1);
    convert(3'b001, 10'd682, 1'b1, 2'd1, 1'b1, 1);
    rd(2'd1, d);
    check("R4 clock reg readback", d, 8'h10);

    // R5 dedicated oscillator, both codes
    convert(3'b011, 10'd777, 1'b1, 2'd0, 1'b0, 0);
    convert(3'b111, 10'd123, 1'b0, 2'd3, 1'b1, 0);

    // R9 writes during busy ignored
    vin = 10'd600;
    wr(2'd1, 8'h60);
    wr(2'd0, 8'h87);
    repeat (40) @(negedge clk);
    wr(2'd0, 8'hCD);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h81);
    check("R9 chan_sel held", chan_sel, 1);
    check("R9 ref_sel held", ref_sel, 0);
    rd(2'd0, d);
    check("R9 busy not cleared by write", d[1], 1);
    wait_irq(3000, n);
    check("R9 conversion finished", n > 0, 1);
    rd(2'd1, d);
    check("R9 clock field held", d, 8'h60);
    rd(2'd3, d);
    check("R9 result", d, exp_lo(10'd600, 1));

    // R10 abort
    vin = 10'd5;
    wr(2'd0, 8'h83);
    repeat (100) @(negedge clk);
    wr(2'd0, 8'h80);
    rd(2'd0, d);
    check("R10 busy cleared by abort", d[1], 0);
    wait_irq(900, n);
    check("R10 no irq after abort", n, -1);
    rd(2'd2, d);
    check("R10 high byte unchanged", d, exp_hi(10'd600, 1));
    rd(2'd3, d);
    check("R10 low byte unchanged", d, exp_lo(10'd600, 1));

    // R12 start without enable
    wr(2'd0, 8'h02);
    rd(2'd0, d);
    check("R12 no start", d[1], 0);
    wait_irq(200, n);
    check("R12 no irq", n, -1);

    // random mix
    for (int i = 0; i < 30; i++) begin
      logic [2:0] s;
      s = ($urandom % 8 == 0) ? 3'b011 : divs[$urandom % 6];
      convert(s, 10'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), s[1:0] != 2'b11);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule